// File: doc/BRIEF.md
# ATM Cell Receiver with Connection Lookup

This block is the receive side of a cell-level UTOPIA Level 2 link toward one PHY. It stays idle until the PHY raises its cell-available line. It then holds its enable high for exactly one cell's worth of byte transfers and reads the whole cell before it makes any decision about it. The cell is a 4-byte ATM header, an optional HEC byte and a 48-byte payload. In user-defined cell mode, a 1 to 12 byte prefix comes before the ATM header.

Once the cell is complete, the VPI/VCI taken from the header is searched in a 16-entry associative table. The table returns a channel code. A cell that misses the table, fails its HEC check, or lacks a start-of-cell mark is dropped. Each dropped cell is reported with a one-cycle result pulse and flags. An accepted cell is reported with the same pulse, and its payload then streams out of an internal buffer as 48 consecutive bytes tagged with the channel code.

Top module: `cell_rx_top`

## Requirements
- R1: After reset, `rx_enb`, `res_valid` and `out_valid` are 0. `rx_enb` rises only in the cycle after `phy_clav` was sampled high while the block was idle.
- R2: `rx_enb` stays high for exactly L consecutive cycles, and each cycle with `rx_enb` high transfers one byte on `phy_data`.
  - In standard mode L = 53.
  - In user-defined mode L = N + 4 + H + 48. N is `cfg_udc_len`, with 0 treated as 1 and values above 12 treated as 12. H is `cfg_udc_hec`.
- R3: When a HEC byte is present and `cfg_hec_en` is 1, the expected HEC is CRC-8 (polynomial x^8+x^2+x+1, zero initial value, MSB first) over the 4 header bytes, XORed with 0x55. A mismatch sets `res_hec_err` and drops the cell.
- R4: With `cfg_hec_en` at 0, or in user-defined mode without a HEC byte, a wrong HEC byte has no effect and the cell is accepted.
- R5: The lookup key is the 24 header bits after the first 4 bits (bits 27:4 of the header, taking header byte 0 as bits 31:24). Among the valid table entries whose key equals it, the lowest index supplies `out_chan`.
- R6: A cell whose key matches no valid entry raises `res_miss`, and none of its payload appears on `out_valid`.
- R7: An accepted cell produces 48 back-to-back `out_valid` cycles carrying its payload bytes in arrival order. `out_sop` is set on the first of these cycles and `out_eop` on the last, and `out_chan` holds the matched code throughout.
- R8: If `phy_soc` is low on the first byte of a cell, `res_soc_err` is set and the cell is dropped.
- R9: Every cell produces exactly one single-cycle `res_valid` pulse, two cycles after its last byte. For an accepted cell, the first `out_valid` cycle follows the pulse by one cycle.
- R10: `rx_enb` stays low while a payload is streaming, even if `phy_clav` is high. A pending cell is read after the stream ends.
- R11: The prefix bytes of a user-defined cell have no influence on the lookup, the HEC or the payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_hec_en | input | 1 | Enable the HEC check |
| cfg_udc_en | input | 1 | User-defined cell mode (prefix before the header) |
| cfg_udc_len | input | 4 | Prefix length in bytes (clamped to 1..12) |
| cfg_udc_hec | input | 1 | A HEC byte is present in user-defined mode |
| tbl_wr_en | input | 1 | Write one lookup table entry |
| tbl_wr_idx | input | 4 | Table entry index |
| tbl_wr_valid | input | 1 | Valid bit of the written entry |
| tbl_wr_key | input | 24 | VPI/VCI key of the written entry |
| tbl_wr_chan | input | 8 | Channel code of the written entry |
| phy_clav | input | 1 | PHY holds a complete cell |
| phy_soc | input | 1 | First byte of a cell on phy_data |
| phy_data | input | 8 | Cell byte from the PHY |
| rx_enb | output | 1 | Read enable; one byte transferred per high cycle |
| res_valid | output | 1 | One-cycle result pulse per cell |
| res_hec_err | output | 1 | HEC mismatch (valid with res_valid) |
| res_miss | output | 1 | No table match (valid with res_valid) |
| res_soc_err | output | 1 | Missing start-of-cell mark (valid with res_valid) |
| out_chan | output | 8 | Matched channel code |
| out_valid | output | 1 | Payload byte valid |
| out_sop | output | 1 | First payload byte |
| out_eop | output | 1 | Last payload byte |
| out_data | output | 8 | Payload byte |

## Verification
The assertions assume that the PHY supplies a byte on every cycle that `rx_enb` is high. They also assume that the configuration inputs and the table stay unchanged while a cell is in flight, since the block latches the configuration only at the start of each cell. The stimulus respects both: the PHY model drives bytes only after it sees the enable, and it changes configuration and table contents only between cells, while the block is idle. Under these conditions the properties check the structure of the handshake, the result pulse and the payload stream, and the bench compares cell lengths, flags, channels and payload bytes against arithmetic models.

// File: rtl/cell_rx_pkg.sv
package cell_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_LOOK,
    ST_DECIDE,
    ST_SEND
  } rx_state_e;

  localparam logic [7:0] HEC_COSET = 8'h55;
  localparam logic [7:0] HEC_POLY  = 8'h07;

  // One byte step of the header CRC, most significant bit first.
  function automatic logic [7:0] crc8_step(input logic [7:0] crc_in, input logic [7:0] d);
    logic [7:0] c;
    c = crc_in ^ d;
    for (int b = 0; b < 8; b++) begin
      c = c[7] ? ((c << 1) ^ HEC_POLY) : (c << 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/cell_rx_hec.sv
module cell_rx_hec import cell_rx_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       en,
  input  logic [7:0] din,
  output logic [7:0] crc
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      crc <= '0;
    end else if (en) begin
      crc <= crc8_step(crc, din);
    end
  end

endmodule

// File: rtl/cell_rx_cam.sv
module cell_rx_cam #(
  parameter int ENTRIES = 16,
  parameter int KEY_W   = 24,
  parameter int CH_W    = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [KEY_W-1:0] wr_key,
  input  logic [CH_W-1:0]  wr_chan,
  input  logic [KEY_W-1:0] lk_key,
  output logic             lk_hit,
  output logic [CH_W-1:0]  lk_chan
);

  logic             ent_v    [ENTRIES];
  logic [KEY_W-1:0] ent_key  [ENTRIES];
  logic [CH_W-1:0]  ent_chan [ENTRIES];
  logic [ENTRIES-1:0] match;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) ent_v[i] <= 1'b0;
    end else if (wr_en) begin
      ent_v[wr_idx] <= wr_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_key[wr_idx]  <= wr_key;
      ent_chan[wr_idx] <= wr_chan;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = ent_v[g] && (ent_key[g] == lk_key);
  end

  // Scan from the top so the lowest matching index is the last to write.
  always_comb begin
    lk_hit  = 1'b0;
    lk_chan = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        lk_hit  = 1'b1;
        lk_chan = ent_chan[i];
      end
    end
  end

endmodule

// File: rtl/cell_rx_buf.sv
module cell_rx_buf #(
  parameter int DEPTH = 48,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/cell_rx_top.sv
module cell_rx_top import cell_rx_pkg::*; #(
  parameter int PAY_BYTES = 48,
  parameter int MAX_EXTRA = 12,
  parameter int TBL_N     = 16,
  parameter int CH_W      = 8,
  localparam int KEY_W    = 24,
  localparam int IDX_W    = $clog2(TBL_N),
  localparam int XW       = $clog2(MAX_EXTRA + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_hec_en,
  input  logic             cfg_udc_en,
  input  logic [XW-1:0]    cfg_udc_len,
  input  logic             cfg_udc_hec,
  input  logic             tbl_wr_en,
  input  logic [IDX_W-1:0] tbl_wr_idx,
  input  logic             tbl_wr_valid,
  input  logic [KEY_W-1:0] tbl_wr_key,
  input  logic [CH_W-1:0]  tbl_wr_chan,
  input  logic             phy_clav,
  input  logic             phy_soc,
  input  logic [7:0]       phy_data,
  output logic             rx_enb,
  output logic             res_valid,
  output logic             res_hec_err,
  output logic             res_miss,
  output logic             res_soc_err,
  output logic [CH_W-1:0]  out_chan,
  output logic             out_valid,
  output logic             out_sop,
  output logic             out_eop,
  output logic [7:0]       out_data
);

  localparam int HDR_BYTES = 4;
  localparam int MAX_CELL  = MAX_EXTRA + HDR_BYTES + 1 + PAY_BYTES;
  localparam int CNT_W     = $clog2(MAX_CELL + 1);
  localparam int AW        = $clog2(PAY_BYTES);
  localparam logic [AW-1:0] LAST_PAY = AW'(PAY_BYTES - 1);

  rx_state_e state;

  // Cell geometry derived from the configuration, latched at cell start.
  logic [XW-1:0]    extra_n;
  logic             n_hec_pres;
  logic [CNT_W-1:0] n_hdr_start, n_pay_start, n_last;

  logic             lat_hec_pres, lat_hec_chk;
  logic [CNT_W-1:0] hdr_start, pay_start, last_idx;

  logic [CNT_W-1:0] byte_cnt;
  logic [CNT_W-1:0] hec_idx;
  logic             take, in_hdr, is_hec, in_pay;

  logic [KEY_W-1:0] key_q;
  logic [7:0]       hec_rx;
  logic [7:0]       hec_crc;
  logic             soc_bad;

  logic             cam_hit;
  logic [CH_W-1:0]  cam_chan;
  logic             hit_q, hec_bad_q;
  logic [CH_W-1:0]  chan_q;

  logic [AW-1:0]    wptr, rd_addr;

  always_comb begin
    if (cfg_udc_len == '0)                   extra_n = XW'(1);
    else if (cfg_udc_len > XW'(MAX_EXTRA))   extra_n = XW'(MAX_EXTRA);
    else                                     extra_n = cfg_udc_len;
    n_hec_pres  = !cfg_udc_en || cfg_udc_hec;
    n_hdr_start = cfg_udc_en ? CNT_W'(extra_n) : '0;
    n_pay_start = n_hdr_start + CNT_W'(HDR_BYTES) + CNT_W'(n_hec_pres);
    n_last      = n_pay_start + CNT_W'(PAY_BYTES - 1);
  end

  always_comb begin
    hec_idx = hdr_start + CNT_W'(HDR_BYTES);
    take    = (state == ST_RECV) && rx_enb;
    in_hdr  = take && (byte_cnt >= hdr_start) && (byte_cnt < hec_idx);
    is_hec  = take && lat_hec_pres && (byte_cnt == hec_idx);
    in_pay  = take && (byte_cnt >= pay_start);
  end

  // VPI/VCI is taken from the middle 24 bits of the 4 header bytes.
  always_ff @(posedge clk) begin
    if (take) begin
      if (byte_cnt == hdr_start)                 key_q[23:20] <= phy_data[3:0];
      if (byte_cnt == hdr_start + CNT_W'(1))     key_q[19:12] <= phy_data;
      if (byte_cnt == hdr_start + CNT_W'(2))     key_q[11:4]  <= phy_data;
      if (byte_cnt == hdr_start + CNT_W'(3))     key_q[3:0]   <= phy_data[7:4];
      if (is_hec)                                hec_rx       <= phy_data;
    end
  end

  cell_rx_hec u_hec (
    .clk (clk),
    .rst (rst),
    .clr (state == ST_IDLE),
    .en  (in_hdr),
    .din (phy_data),
    .crc (hec_crc)
  );

  cell_rx_cam #(
    .ENTRIES (TBL_N),
    .KEY_W   (KEY_W),
    .CH_W    (CH_W)
  ) u_cam (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (tbl_wr_en),
    .wr_idx   (tbl_wr_idx),
    .wr_valid (tbl_wr_valid),
    .wr_key   (tbl_wr_key),
    .wr_chan  (tbl_wr_chan),
    .lk_key   (key_q),
    .lk_hit   (cam_hit),
    .lk_chan  (cam_chan)
  );

  cell_rx_buf #(
    .DEPTH (PAY_BYTES),
    .W     (8)
  ) u_buf (
    .clk   (clk),
    .we    (in_pay),
    .waddr (wptr),
    .wdata (phy_data),
    .raddr (rd_addr),
    .rdata (out_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      rx_enb       <= 1'b0;
      byte_cnt     <= '0;
      wptr         <= '0;
      rd_addr      <= '0;
      soc_bad      <= 1'b0;
      lat_hec_pres <= 1'b1;
      lat_hec_chk  <= 1'b0;
      hdr_start    <= '0;
      pay_start    <= '0;
      last_idx     <= '0;
      hit_q        <= 1'b0;
      hec_bad_q    <= 1'b0;
      chan_q       <= '0;
      res_valid    <= 1'b0;
      res_hec_err  <= 1'b0;
      res_miss     <= 1'b0;
      res_soc_err  <= 1'b0;
      out_chan     <= '0;
      out_valid    <= 1'b0;
      out_sop      <= 1'b0;
      out_eop      <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      case (state)
        ST_IDLE: begin
          byte_cnt <= '0;
          wptr     <= '0;
          soc_bad  <= 1'b0;
          if (phy_clav) begin
            lat_hec_pres <= n_hec_pres;
            lat_hec_chk  <= cfg_hec_en && n_hec_pres;
            hdr_start    <= n_hdr_start;
            pay_start    <= n_pay_start;
            last_idx     <= n_last;
            rx_enb       <= 1'b1;
            state        <= ST_RECV;
          end
        end
        ST_RECV: begin
          if (rx_enb) begin
            if (byte_cnt == '0 && !phy_soc) soc_bad <= 1'b1;
            if (in_pay) wptr <= wptr + AW'(1);
            if (byte_cnt == last_idx) begin
              rx_enb <= 1'b0;
              state  <= ST_LOOK;
            end
            byte_cnt <= byte_cnt + CNT_W'(1);
          end
        end
        ST_LOOK: begin
          hit_q     <= cam_hit;
          chan_q    <= cam_chan;
          hec_bad_q <= lat_hec_chk && ((hec_crc ^ HEC_COSET) != hec_rx);
          state     <= ST_DECIDE;
        end
        ST_DECIDE: begin
          res_valid   <= 1'b1;
          res_miss    <= !hit_q;
          res_hec_err <= hec_bad_q;
          res_soc_err <= soc_bad;
          out_chan    <= chan_q;
          rd_addr     <= '0;
          state       <= (hit_q && !hec_bad_q && !soc_bad) ? ST_SEND : ST_IDLE;
        end
        ST_SEND: begin
          out_valid <= 1'b1;
          out_sop   <= (rd_addr == '0);
          out_eop   <= (rd_addr == LAST_PAY);
          rd_addr   <= rd_addr + AW'(1);
          if (rd_addr == LAST_PAY) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cell_rx_chk.sv
module cell_rx_chk #(
  parameter int PAY_BYTES = 48,
  parameter int MAX_LEN   = 65
) (
  input logic clk,
  input logic rst,
  input logic phy_clav,
  input logic rx_enb,
  input logic res_valid,
  input logic res_miss,
  input logic res_hec_err,
  input logic res_soc_err,
  input logic out_valid,
  input logic out_sop,
  input logic out_eop
);

  int unsigned run_cnt;
  int unsigned enb_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= 0;
      enb_cnt <= 0;
    end else begin
      run_cnt <= out_valid ? run_cnt + 1 : 0;
      enb_cnt <= rx_enb ? enb_cnt + 1 : 0;
    end
  end

  assert_start_on_clav_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_enb) |-> $past(phy_clav));

  assert_enb_bounded_R2: assert property (@(posedge clk) disable iff (rst)
    rx_enb |-> (enb_cnt < MAX_LEN));

  // Covers dropped cells of R3, R6 and R8.
  assert_drop_silent_R6: assert property (@(posedge clk) disable iff (rst)
    res_valid && (res_miss || res_hec_err || res_soc_err) |=> !out_valid);

  assert_sop_first_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> out_sop);

  assert_eop_ends_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_eop |=> !out_valid);

  assert_payload_len_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_eop |-> (run_cnt == PAY_BYTES - 1));

  assert_res_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  assert_accept_streams_R9: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_miss && !res_hec_err && !res_soc_err |=> out_valid && out_sop);

  assert_no_read_in_send_R10: assert property (@(posedge clk) disable iff (rst)
    !(rx_enb && out_valid));

endmodule

bind cell_rx_top cell_rx_chk #(
  .PAY_BYTES (PAY_BYTES),
  .MAX_LEN   (MAX_CELL)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .phy_clav    (phy_clav),
  .rx_enb      (rx_enb),
  .res_valid   (res_valid),
  .res_miss    (res_miss),
  .res_hec_err (res_hec_err),
  .res_soc_err (res_soc_err),
  .out_valid   (out_valid),
  .out_sop     (out_sop),
  .out_eop     (out_eop)
);

// File: tb/tb_cell_rx_top.sv
`timescale 1ns/1ps
module tb_cell_rx_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_hec_en, cfg_udc_en, cfg_udc_hec;
  logic [3:0]  cfg_udc_len;
  logic        tbl_wr_en, tbl_wr_valid;
  logic [3:0]  tbl_wr_idx;
  logic [23:0] tbl_wr_key;
  logic [7:0]  tbl_wr_chan;
  logic        phy_clav, phy_soc;
  logic [7:0]  phy_data;
  logic        rx_enb, res_valid, res_hec_err, res_miss, res_soc_err;
  logic [7:0]  out_chan, out_data;
  logic        out_valid, out_sop, out_eop;

  int n_checks = 0;
  int n_errs   = 0;
  int seed_ctr = 0;

  logic [7:0]  cell_b  [0:79];
  int          cell_len;
  logic [7:0]  exp_pay [0:47];

  logic        sh_v [0:15];
  logic [23:0] sh_k [0:15];
  logic [7:0]  sh_c [0:15];

  always #10 clk = ~clk;

  cell_rx_top dut (
    .clk(clk), .rst(rst),
    .cfg_hec_en(cfg_hec_en), .cfg_udc_en(cfg_udc_en),
    .cfg_udc_len(cfg_udc_len), .cfg_udc_hec(cfg_udc_hec),
    .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_valid(tbl_wr_valid),
    .tbl_wr_key(tbl_wr_key), .tbl_wr_chan(tbl_wr_chan),
    .phy_clav(phy_clav), .phy_soc(phy_soc), .phy_data(phy_data),
    .rx_enb(rx_enb), .res_valid(res_valid), .res_hec_err(res_hec_err),
    .res_miss(res_miss), .res_soc_err(res_soc_err), .out_chan(out_chan),
    .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Polynomial long division of header*x^8 by 0x107, then the coset.
  function automatic logic [7:0] hec_of(input logic [31:0] h);
    logic [39:0] r;
    r = {h, 8'h00};
    for (int i = 39; i >= 8; i--) begin
      if (r[i]) r = r ^ (40'h107 << (i - 8));
    end
    return r[7:0] ^ 8'h55;
  endfunction

  function automatic logic [23:0] key_of(input int i);
    return {8'(i * 3 + 1), 16'(16'h0100 + i * 37)};
  endfunction

  task automatic tbl_write(input int idx, input bit v, input logic [23:0] k, input logic [7:0] c);
    tbl_wr_en = 1; tbl_wr_idx = 4'(idx); tbl_wr_valid = v; tbl_wr_key = k; tbl_wr_chan = c;
    sh_v[idx] = v; sh_k[idx] = k; sh_c[idx] = c;
    @(negedge clk);
    tbl_wr_en = 0;
  endtask

  task automatic build(input logic [23:0] key, input int n_extra, input bit hec_pres,
                       input bit bad_hec, input logic [7:0] seed);
    logic [31:0] h;
    int p = 0;
    h = {seed[3:0], key, seed[7:4]};
    for (int e = 0; e < n_extra; e++) begin cell_b[p] = 8'(8'hC0 + e) ^ seed; p++; end
    for (int b = 0; b < 4; b++) begin cell_b[p] = h[31 - 8*b -: 8]; p++; end
    if (hec_pres) begin cell_b[p] = hec_of(h) ^ (bad_hec ? 8'h01 : 8'h00); p++; end
    for (int j = 0; j < 48; j++) begin
      exp_pay[j] = 8'(seed + j * 7);
      cell_b[p] = exp_pay[j]; p++;
    end
    cell_len = p;
  endtask

  task automatic send_cell(input bit with_soc, output int enb_cycles);
    int i = 0;
    bit done = 0;
    enb_cycles = 0;
    phy_clav = 1;
    while (!done) begin
      @(negedge clk);
      phy_soc = 0;
      if (rx_enb) begin
        enb_cycles++;
        phy_data = (i < cell_len) ? cell_b[i] : 8'h00;
        phy_soc  = (i == 0) && with_soc;
        phy_clav = 0;
        i++;
      end else if (i > 0) begin
        done = 1;
      end
    end
  endtask

  task automatic run_cell(input string req, input logic [23:0] key, input int n_extra,
                          input bit hec_pres, input bit bad_hec, input bit soc,
                          input int exp_len, input bit exp_hec, input bit exp_soc,
                          input bit clav_during);
    int enb_n, w, bad, rd_bad, leak;
    bit hit, acc;
    logic [7:0] chan;
    hit = 0; chan = 0;
    for (int i = 15; i >= 0; i--) begin
      if (sh_v[i] && sh_k[i] == key) begin hit = 1; chan = sh_c[i]; end
    end
    seed_ctr++;
    build(key, n_extra, hec_pres, bad_hec, 8'(seed_ctr * 29 + 5));
    send_cell(soc, enb_n);
    chk(req, "enable cycles (R2)", enb_n, exp_len);
    w = 0;
    while (!res_valid && w < 10) begin @(negedge clk); w++; end
    chk(req, "result pulse delay (R9)", w, 2);
    chk(req, "miss flag (R6)", int'(res_miss), int'(!hit));
    chk(req, "hec flag (R3)", int'(res_hec_err), int'(exp_hec));
    chk(req, "soc flag (R8)", int'(res_soc_err), int'(exp_soc));
    if (hit) chk(req, "channel (R5)", int'(out_chan), int'(chan));
    acc = hit && !exp_hec && !exp_soc;
    @(negedge clk);
    chk(req, "pulse width (R9)", int'(res_valid), 0);
    if (acc) begin
      bad = 0; rd_bad = 0;
      for (int j = 0; j < 48; j++) begin
        if (j > 0) @(negedge clk);
        if (clav_during) phy_clav = 1;
        if (!out_valid || out_data != exp_pay[j] || out_sop != (j == 0) ||
            out_eop != (j == 47) || out_chan != chan) bad++;
        if (rx_enb) rd_bad++;
      end
      chk(req, "payload stream errors (R7)", bad, 0);
      if (clav_during) chk("R10", "enable during stream", rd_bad, 0);
    end else begin
      leak = 0;
      for (int j = 0; j < 4; j++) begin
        if (out_valid) leak++;
        @(negedge clk);
      end
      chk(req, "payload leaked on drop (R6)", leak, 0);
    end
  endtask

  initial begin
    #(20.0 * 150000);
    n_errs++;
    $display("FAIL watchdog: actual 0 expected 1 completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    int cnt;
    rst = 1; cfg_hec_en = 1; cfg_udc_en = 0; cfg_udc_hec = 0; cfg_udc_len = 0;
    tbl_wr_en = 0; tbl_wr_idx = 0; tbl_wr_valid = 0; tbl_wr_key = 0; tbl_wr_chan = 0;
    phy_clav = 0; phy_soc = 0; phy_data = 0;
    for (int i = 0; i < 16; i++) begin sh_v[i] = 0; sh_k[i] = 0; sh_c[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R1", "reset rx_enb", int'(rx_enb), 0);
    chk("R1", "reset out_valid", int'(out_valid), 0);
    chk("R1", "reset res_valid", int'(res_valid), 0);
    rst = 0;

    cnt = 0;
    for (int c = 0; c < 20; c++) begin @(negedge clk); if (rx_enb) cnt++; end
    chk("R1", "enable without cell available", cnt, 0);

    // Table: entry 9 duplicates entry 5 (R5 priority), entry 15 is invalid (R6).
    for (int i = 0; i < 16; i++) begin
      if (i == 9)       tbl_write(i, 1, key_of(5), 8'h99);
      else if (i == 15) tbl_write(i, 0, key_of(15), 8'h4F);
      else              tbl_write(i, 1, key_of(i), 8'(8'h40 + i));
    end

    // Standard cells over every table key.
    for (int i = 0; i < 16; i++) begin
      run_cell("R5", key_of(i), 0, 1, 0, 1, 53, 0, 0, 0);
    end
    run_cell("R6", 24'hABCDEF, 0, 1, 0, 1, 53, 0, 0, 0);

    run_cell("R3", key_of(2), 0, 1, 1, 1, 53, 1, 0, 0);
    run_cell("R3", 24'h123456, 0, 1, 1, 1, 53, 1, 0, 0);
    cfg_hec_en = 0;
    run_cell("R4", key_of(3), 0, 1, 1, 1, 53, 0, 0, 0);
    cfg_hec_en = 1;

    run_cell("R8", key_of(4), 0, 1, 0, 0, 53, 0, 1, 0);

    // User-defined cells: every prefix length, with and without a HEC byte.
    cfg_udc_en = 1;
    for (int n = 1; n <= 12; n++) begin
      for (int h = 0; h < 2; h++) begin
        cfg_udc_len = 4'(n); cfg_udc_hec = h[0];
        run_cell("R11", key_of(n), n, h[0], (h == 0), 1, n + 4 + h + 48, 0, 0, 0);
      end
    end
    cfg_udc_len = 4'd7; cfg_udc_hec = 1;
    run_cell("R3", key_of(1), 7, 1, 1, 1, 60, 1, 0, 0);
    cfg_udc_len = 4'd0; cfg_udc_hec = 1;
    run_cell("R2", key_of(6), 1, 1, 0, 1, 54, 0, 0, 0);
    cfg_udc_len = 4'd15; cfg_udc_hec = 1;
    run_cell("R2", key_of(7), 12, 1, 0, 1, 65, 0, 0, 0);
    cfg_udc_len = 4'd3; cfg_udc_hec = 0; cfg_hec_en = 1;
    run_cell("R4", key_of(8), 3, 0, 0, 1, 55, 0, 0, 0);
    cfg_udc_en = 0;

    // A cell becomes available while the previous payload streams.
    run_cell("R10", key_of(10), 0, 1, 0, 1, 53, 0, 0, 1);
    run_cell("R10", key_of(11), 0, 1, 0, 1, 53, 0, 0, 0);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

endmodule